// File: doc/BRIEF.md
# Packed Mixed-Sign Byte Multiply-Add Unit

This SIMD datapath accepts two 256-bit operand vectors. In every byte position it multiplies an unsigned byte of the first vector by the signed byte in the same position of the second vector. Each pair of neighbouring 16-bit products is then summed, and the sum is clamped to a signed 16-bit word. Byte pair 2k/2k+1 therefore yields result word k.

A two-bit mode input sets how much of the result is computed and how the bits above that are filled. The fill can come from a separate prior-destination vector or be forced to zero. The unit is a two-stage pipeline: products are registered first, saturated words second. A valid/ready handshake guards it, and the whole pipe freezes while the consumer stalls.

Top module: `pmadd_unit`

## Requirements
- R1: Each product treats the first-operand byte as unsigned (0..255) and the second-operand byte as signed (-128..127); for example 0x80 times 0xFF gives -128, not +128.
- R2: Result word k (bits 16k+15:16k) is the pair sum of the products from bytes 2k and 2k+1, computed wide enough that no intermediate overflow is lost.
- R3: A pair sum above 32767 is output as 0x7FFF.
- R4: A pair sum below -32768 is output as 0x8000.
- R5: Mode 0 (64-bit) computes words 0..3; result bits 255:64 equal the prior-destination input.
- R6: Mode 1 (128-bit, keep) computes words 0..7; result bits 255:128 equal the prior-destination input.
- R7: Mode 2 (128-bit, clear) computes words 0..7; result bits 255:128 are zero.
- R8: Mode 3 (256-bit) computes all 16 words.
- R9: An input accepted at clock edge E, with out_ready high, appears with out_valid high after edge E+1, and not after edge E.
- R10: While out_valid is high and out_ready is low, in_ready is low and out_valid and out_data hold their values.
- R11: Results leave in the order their inputs were accepted. An input accepted behind a stalled result is delivered after the stall clears.
- R12: After synchronous reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_mode | input | 2 | 0 = 64-bit, 1 = 128-bit keep, 2 = 128-bit clear, 3 = 256-bit |
| in_ua | input | 256 | First operand, unsigned bytes |
| in_sb | input | 256 | Second operand, signed bytes |
| in_prior | input | 256 | Prior destination value for upper fill |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Packed saturated words |

## Verification
The bench targets both saturation edges: 0xFF×0x7F in both bytes of a pair must clamp to 0x7FFF, and 0xFF×0x80 in both bytes must clamp to 0x8000. A narrow sum would wrap instead of clamping. A 0x80×0xFF pair shows whether the first byte is really read as unsigned, since a fully signed multiplier returns +128. Each mode gets distinct prior-destination data, so a mode that selects the wrong upper fill, or a wrong boundary at bit 64 or bit 128, shows up as a mismatch. Stall and back-to-back tests catch a pipe that drops a stalled result, lets it change, or reorders it against the input behind it.

// File: rtl/pmadd_pkg.sv
`timescale 1ns/1ps
package pmadd_pkg;
    localparam int VEC_W    = 256;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int N_BYTES  = VEC_W / BYTE_W;
    localparam int N_WORDS  = N_BYTES / 2;
    localparam int PROD_W   = 2 * BYTE_W;
    localparam int SUM_W    = PROD_W + 2;
    localparam int NARROW_W = 4;   // words computed in 64-bit mode
    localparam int HALF_W   = 8;   // words computed in 128-bit modes

    typedef enum logic [1:0] {
        MODE_NARROW64   = 2'd0,
        MODE_HALF_KEEP  = 2'd1,
        MODE_HALF_CLEAR = 2'd2,
        MODE_FULL       = 2'd3
    } pmadd_mode_e;

    typedef enum logic [1:0] {
        SRC_CALC  = 2'd0,
        SRC_PRIOR = 2'd1,
        SRC_ZERO  = 2'd2
    } word_src_e;

    typedef struct packed {
        pmadd_mode_e        mode;
        logic [VEC_W-1:0]   prior;
    } pmadd_ctl_t;

    // unsigned byte times signed byte, exact in 16 bits signed
    function automatic logic [PROD_W-1:0] mul_us(input logic [BYTE_W-1:0] u,
                                                 input logic [BYTE_W-1:0] s);
        logic signed [SUM_W-1:0] a;
        logic signed [SUM_W-1:0] b;
        logic signed [SUM_W-1:0] p;
        a = $signed({{(SUM_W-BYTE_W){1'b0}}, u});
        b = $signed({{(SUM_W-BYTE_W){s[BYTE_W-1]}}, s});
        p = a * b;
        return p[PROD_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] sat_word(input logic signed [SUM_W-1:0] v);
        if (v > $signed(SUM_W'(32767)))
            return 16'h7FFF;
        else if (v < -$signed(SUM_W'(32768)))
            return 16'h8000;
        else
            return v[WORD_W-1:0];
    endfunction

    function automatic word_src_e word_source(input pmadd_mode_e m, input int k);
        if (k < NARROW_W)
            return SRC_CALC;
        else if (k < HALF_W)
            return (m == MODE_NARROW64) ? SRC_PRIOR : SRC_CALC;
        else if (m == MODE_FULL)
            return SRC_CALC;
        else if (m == MODE_HALF_CLEAR)
            return SRC_ZERO;
        else
            return SRC_PRIOR;
    endfunction
endpackage

// File: rtl/pmadd_prod_stage.sv
`timescale 1ns/1ps
module pmadd_prod_stage
    import pmadd_pkg::*;
#(
    parameter int NB = N_BYTES
) (
    input  logic                            clk,
    input  logic                            load,
    input  logic [NB*BYTE_W-1:0]            ua,
    input  logic [NB*BYTE_W-1:0]            sb,
    input  pmadd_ctl_t                      ctl_in,
    output logic [NB-1:0][PROD_W-1:0]       prod_q,
    output pmadd_ctl_t                      ctl_q
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (load)
                prod_q[b] <= mul_us(ua[b*BYTE_W +: BYTE_W], sb[b*BYTE_W +: BYTE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (load)
            ctl_q <= ctl_in;
    end
endmodule

// File: rtl/pmadd_sum_stage.sv
`timescale 1ns/1ps
module pmadd_sum_stage
    import pmadd_pkg::*;
#(
    parameter int NW = N_WORDS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load,
    input  logic [2*NW-1:0][PROD_W-1:0]     prod_in,
    input  pmadd_ctl_t                      ctl_in,
    output logic [NW*WORD_W-1:0]            data_q
);
    logic [NW*WORD_W-1:0] data_d;

    for (genvar k = 0; k < NW; k++) begin : g_word
        logic signed [SUM_W-1:0] pair_sum;
        logic [WORD_W-1:0]       sat_val;
        word_src_e               src;

        always_comb begin
            pair_sum = $signed({{(SUM_W-PROD_W){prod_in[2*k][PROD_W-1]}},   prod_in[2*k]})
                     + $signed({{(SUM_W-PROD_W){prod_in[2*k+1][PROD_W-1]}}, prod_in[2*k+1]});
            sat_val  = sat_word(pair_sum);
            src      = word_source(ctl_in.mode, k);
            unique case (src)
                SRC_CALC:  data_d[k*WORD_W +: WORD_W] = sat_val;
                SRC_PRIOR: data_d[k*WORD_W +: WORD_W] = ctl_in.prior[k*WORD_W +: WORD_W];
                default:   data_d[k*WORD_W +: WORD_W] = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (load)
            data_q <= data_d;
    end

    // R7: clear mode leaves nothing above bit 127
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        load && ctl_in.mode == MODE_HALF_CLEAR |=> data_q[NW*WORD_W-1:HALF_W*WORD_W] == '0);

    // R5: narrow mode carries the prior value above bit 63
    a_r5_narrow_prior: assert property (@(posedge clk) disable iff (rst)
        load && ctl_in.mode == MODE_NARROW64 |=>
            data_q[NW*WORD_W-1:NARROW_W*WORD_W] == $past(ctl_in.prior[NW*WORD_W-1:NARROW_W*WORD_W]));

    // R6: keep mode carries the prior value above bit 127
    a_r6_keep_prior: assert property (@(posedge clk) disable iff (rst)
        load && ctl_in.mode == MODE_HALF_KEEP |=>
            data_q[NW*WORD_W-1:HALF_W*WORD_W] == $past(ctl_in.prior[NW*WORD_W-1:HALF_W*WORD_W]));
endmodule

// File: rtl/pmadd_unit.sv
`timescale 1ns/1ps
module pmadd_unit
    import pmadd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_mode,
    input  logic [VEC_W-1:0]   in_ua,
    input  logic [VEC_W-1:0]   in_sb,
    input  logic [VEC_W-1:0]   in_prior,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [VEC_W-1:0]   out_data
);
    logic                          s1_valid_q;
    logic                          s2_valid_q;
    logic                          advance;
    logic                          load_s1;
    logic                          load_s2;
    pmadd_ctl_t                    ctl_in;
    pmadd_ctl_t                    ctl_s1;
    logic [N_BYTES-1:0][PROD_W-1:0] prod_s1;

    assign advance  = !s2_valid_q || out_ready;
    assign in_ready = advance;
    assign load_s1  = advance && in_valid;
    assign load_s2  = advance && s1_valid_q;

    assign ctl_in.mode  = pmadd_mode_e'(in_mode);
    assign ctl_in.prior = in_prior;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid_q <= 1'b0;
            s2_valid_q <= 1'b0;
        end else if (advance) begin
            s1_valid_q <= in_valid;
            s2_valid_q <= s1_valid_q;
        end
    end

    pmadd_prod_stage #(.NB(N_BYTES)) u_prod (
        .clk    (clk),
        .load   (load_s1),
        .ua     (in_ua),
        .sb     (in_sb),
        .ctl_in (ctl_in),
        .prod_q (prod_s1),
        .ctl_q  (ctl_s1)
    );

    pmadd_sum_stage #(.NW(N_WORDS)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .load    (load_s2),
        .prod_in (prod_s1),
        .ctl_in  (ctl_s1),
        .data_q  (out_data)
    );

    assign out_valid = s2_valid_q;

    // R12: reset empties the pipe
    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready);

    // R10: stalled result holds
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R10: stall blocks intake
    a_r10_no_intake: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R9: two-edge latency with a ready consumer
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready ##1 out_ready |=> out_valid);
endmodule

// File: tb/tb_pmadd_unit.sv
`timescale 1ns/1ps
module tb_pmadd_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [1:0]   in_mode;
    logic [255:0] in_ua;
    logic [255:0] in_sb;
    logic [255:0] in_prior;
    logic         out_valid;
    logic         out_ready;
    logic [255:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pmadd_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_ua(in_ua), .in_sb(in_sb), .in_prior(in_prior),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // {mode, ua seed, sb seed, prior seed}
    localparam logic [31:0] VTAB [12] = '{
        32'h03_11_05_A0, 32'h03_FF_7F_01, 32'h03_80_FF_22, 32'h03_F0_83_5A,
        32'h00_37_C1_3C, 32'h00_FE_7E_E7, 32'h01_91_22_99, 32'h01_0D_F7_6B,
        32'h02_C3_45_18, 32'h02_FF_80_77, 32'h03_00_00_FF, 32'h02_5E_9B_C4
    };

    function automatic logic [255:0] spread(input logic [7:0] seed, input int step);
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'(seed + i * step);
        return v;
    endfunction

    function automatic logic [255:0] ref_model(input logic [1:0] m, input logic [255:0] a,
                                               input logic [255:0] b, input logic [255:0] p);
        logic [255:0] r;
        for (int k = 0; k < 16; k++) begin
            int s;
            logic [15:0] w;
            s = int'(a[16*k +: 8]) * int'($signed(b[16*k +: 8]))
              + int'(a[16*k+8 +: 8]) * int'($signed(b[16*k+8 +: 8]));
            if (s > 32767) w = 16'h7FFF;
            else if (s < -32768) w = 16'h8000;
            else w = 16'(s);
            if (k < 4) r[16*k +: 16] = w;
            else if (k < 8) r[16*k +: 16] = (m == 2'd0) ? p[16*k +: 16] : w;
            else if (m == 2'd3) r[16*k +: 16] = w;
            else if (m == 2'd2) r[16*k +: 16] = '0;
            else r[16*k +: 16] = p[16*k +: 16];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [255:0] a,
                         input logic [255:0] b, input logic [255:0] p);
        in_mode = m; in_ua = a; in_sb = b; in_prior = p; in_valid = 1'b1;
    endtask

    // one transaction with a ready consumer; called at a negedge
    task automatic run_one(input logic [1:0] m, input logic [255:0] a,
                           input logic [255:0] b, input logic [255:0] p, input string req);
        logic [255:0] exp;
        exp = ref_model(m, a, b, p);
        out_ready = 1'b1;
        drive(m, a, b, p);
        @(negedge clk);               // accepted at edge E
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R9 early", {255'd0, out_valid}, 256'd0);
        @(negedge clk);               // edge E+1
        check(out_valid == 1'b1, "R9 valid", {255'd0, out_valid}, 256'd1);
        check(out_data == exp, req, out_data, exp);
        @(negedge clk);
    endtask

    initial begin
        logic [255:0] ea, eb, d_hold;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_mode = '0; in_ua = '0; in_sb = '0; in_prior = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12
        check(out_valid == 1'b0, "R12 out_valid", {255'd0, out_valid}, 256'd0);
        check(in_ready == 1'b1, "R12 in_ready", {255'd0, in_ready}, 256'd1);

        // table walk: R2, R5, R6, R7, R8
        for (int i = 0; i < 12; i++) begin
            logic [31:0] e;
            e = VTAB[i];
            run_one(e[25:24], spread(e[23:16], 37), spread(e[15:8], 53),
                    spread(e[7:0], 91), "R2/R5/R6/R7/R8 table");
        end

        // R3: 255*127 twice clamps high
        run_one(2'd3, {32{8'hFF}}, {32{8'h7F}}, '0, "R3 sat high");
        // R4: 255*-128 twice clamps low
        run_one(2'd3, {32{8'hFF}}, {32{8'h80}}, '0, "R4 sat low");
        // R1: 0x80 unsigned times -1 gives -256 per pair
        run_one(2'd3, {32{8'h80}}, {32{8'hFF}}, '0, "R1 unsigned first");
        // R5 / R6 / R7 with patterned prior
        run_one(2'd0, {32{8'h12}}, {32{8'h34}}, {8{32'hDEADBEEF}}, "R5 narrow prior");
        run_one(2'd1, {32{8'h56}}, {32{8'hF8}}, {8{32'hCAFEF00D}}, "R6 keep prior");
        run_one(2'd2, {32{8'h9A}}, {32{8'h0B}}, {8{32'h5A5A5A5A}}, "R7 clear upper");
        // R8: mixed full width
        run_one(2'd3, spread(8'h01, 5), spread(8'hF0, 3), '1, "R8 full width");

        // R10 / R11: two back-to-back inputs, consumer stalled
        ea = ref_model(2'd3, {32{8'h21}}, {32{8'h43}}, '0);
        eb = ref_model(2'd2, {32{8'hFF}}, {32{8'h80}}, '1);
        out_ready = 1'b0;
        drive(2'd3, {32{8'h21}}, {32{8'h43}}, '0);
        @(negedge clk);               // A accepted
        drive(2'd2, {32{8'hFF}}, {32{8'h80}}, '1);
        @(negedge clk);               // B accepted, A at output
        in_valid = 1'b0;
        check(out_valid && out_data == ea, "R11 first out", out_data, ea);
        d_hold = out_data;
        for (int c = 0; c < 3; c++) begin
            drive(2'd0, '1, '1, '1);  // offered but must not enter
            @(negedge clk);
            check(in_ready == 1'b0, "R10 in_ready low", {255'd0, in_ready}, 256'd0);
            check(out_valid && out_data == d_hold, "R10 hold", out_data, d_hold);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid && out_data == eb, "R11 second out", out_data, eb);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drained", {255'd0, out_valid}, 256'd0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule